// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the two error counters of a CAN node and decides, from their values, whether the node is error active, error passive or bus off. The protocol engine feeds it single-cycle event pulses. There is one pulse each for a transmit error, a receive error, a dominant-bit sequence error seen after an error or overload flag, a good transmission and a good reception. The engine also supplies a strobe once per sampled bit, together with the level that was sampled.

The outputs are both counter values, the confinement state and a flag that tells the engine whether its error flags must be passive. There is also a sticky recovery interrupt. While the node is bus off, the receive counter is reused to count runs of 11 recessive bits. After 128 such runs the node goes back on the bus with clean counters.

Top module: `can_fault_conf`

## Requirements
- R1: After reset both counters read 0, the state is error active (`state_o` = 2'b00), `err_passive_o` is 0 and `recov_irq_o` is 0.
- R2: Outside bus off, a `tx_err_i` pulse adds 8 to the transmit counter. A `dom_seq_err_i` pulse adds 8 to both counters.
- R3: Outside bus off, a `rx_err_i` pulse adds 8 to the receive counter while it is below 128. From 128 upward, receive errors leave it unchanged.
- R4: Outside bus off, a `tx_ok_i` pulse lowers a nonzero transmit counter by 1. At 0 the counter stays 0.
- R5: Outside bus off, a `rx_ok_i` pulse lowers the receive counter by 1 when it is 1 to 127. It leaves 0 unchanged, and it reloads any value above 127 to 120.
- R6: When an increment and a decrement reach the same counter in one cycle, only the increment takes effect.
- R7: Outside bus off, `state_o` is 2'b01 (error passive) when either counter is 128 or more, and 2'b00 when both are 127 or less. `err_passive_o` is 1 exactly when the state is 2'b01.
- R8: When a transmit-counter increment would bring it to 256 or more, the node enters bus off (`state_o` = 2'b10). Both counters read 0 in the next cycle.
- R9: While bus off, all five event pulses are ignored. Each strobe with `bit_lvl_i` = 1 (recessive) extends the current run. The 11th consecutive recessive strobe adds 1 to the receive counter and starts a new run. A strobe with `bit_lvl_i` = 0 restarts the run.
- R10: The run that would bring the receive counter to 128 returns the node to error active with both counters at 0 and sets `recov_irq_o`. The flag stays set until an `irq_ack_i` pulse, and a new recovery in the same cycle as the acknowledge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err_i | input | 1 | Transmit error event |
| rx_err_i | input | 1 | Receive error event |
| dom_seq_err_i | input | 1 | Dominant-bit sequence error after an error or overload flag (both counters) |
| tx_ok_i | input | 1 | Frame transmitted without error and acknowledged |
| rx_ok_i | input | 1 | Frame received without error and acknowledge sent |
| bit_stb_i | input | 1 | One pulse per sampled bus bit |
| bit_lvl_i | input | 1 | Sampled level, 1 = recessive |
| irq_ack_i | input | 1 | Clears the recovery interrupt |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 8 | Receive error counter, or recessive-run count while bus off |
| state_o | output | 2 | 00 error active, 01 error passive, 10 bus off |
| err_passive_o | output | 1 | Error flags must be passive |
| recov_irq_o | output | 1 | Bus-off recovery interrupt |

## Verification
The hardest situation to reach is a full bus-off recovery. It requires the transmit counter to be driven past 255 and then more than 1400 recessive strobes, in runs that are not broken by dominant samples. The bench gets there once with a directed sequence that also places a dominant strobe inside a run. After that, random phases weight transmit errors heavily and make strobes mostly recessive, so the node passes through bus off and back several times with events arriving during the recovery. A bench reference model, built from the requirements, is compared with every output in every cycle.

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
  parameter int TEC_W    = 9,
  parameter int REC_W    = 8,
  parameter int STEP     = 8,
  parameter int PASS_LIM = 128,
  parameter int OFF_LIM  = 256,
  parameter int RELOAD   = 120,
  parameter int RUN_LEN  = 11,
  parameter int RUN_GOAL = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err_i,
  input  logic             rx_err_i,
  input  logic             dom_seq_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic             bit_stb_i,
  input  logic             bit_lvl_i,
  input  logic             irq_ack_i,
  output logic [TEC_W-1:0] tec_o,
  output logic [REC_W-1:0] rec_o,
  output logic [1:0]       state_o,
  output logic             err_passive_o,
  output logic             recov_irq_o
);
  localparam int RUN_W = $clog2(RUN_LEN);
  localparam logic [1:0] ST_ACT = 2'b00, ST_PAS = 2'b01, ST_OFF = 2'b10;
  localparam logic [TEC_W:0]   TEC_STEP = (TEC_W+1)'(STEP);
  localparam logic [TEC_W:0]   TEC_OFF  = (TEC_W+1)'(OFF_LIM);
  localparam logic [TEC_W-1:0] TEC_PAS  = TEC_W'(PASS_LIM);
  localparam logic [REC_W-1:0] REC_PAS  = REC_W'(PASS_LIM);
  localparam logic [REC_W-1:0] REC_STEP = REC_W'(STEP);
  localparam logic [REC_W-1:0] REC_RLD  = REC_W'(RELOAD);
  localparam logic [REC_W-1:0] REC_GOAL = REC_W'(RUN_GOAL - 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

  logic [TEC_W-1:0] tec_q;
  logic [REC_W-1:0] rec_q;
  logic [RUN_W-1:0] run_q;
  logic             off_q, irq_q;

  wire tx_up = tx_err_i | dom_seq_err_i;
  wire rx_up = rx_err_i | dom_seq_err_i;
  wire [TEC_W:0] tec_sum = {1'b0, tec_q} + TEC_STEP;
  wire hit_off  = tx_up && (tec_sum >= TEC_OFF);
  wire run_done = bit_stb_i && bit_lvl_i && (run_q == RUN_LAST);
  wire recover  = off_q && run_done && (rec_q == REC_GOAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q <= '0;
      rec_q <= '0;
      run_q <= '0;
      off_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (recover) irq_q <= 1'b1;
      else if (irq_ack_i) irq_q <= 1'b0;

      if (off_q) begin
        if (bit_stb_i) begin
          if (!bit_lvl_i) run_q <= '0;
          else if (run_q == RUN_LAST) begin
            run_q <= '0;
            if (recover) begin
              off_q <= 1'b0;
              rec_q <= '0;
              tec_q <= '0;
            end else begin
              rec_q <= rec_q + 1'b1;
            end
          end else begin
            run_q <= run_q + 1'b1;
          end
        end
      end else if (hit_off) begin
        off_q <= 1'b1;
        tec_q <= '0;
        rec_q <= '0;
        run_q <= '0;
      end else begin
        if (tx_up) tec_q <= tec_sum[TEC_W-1:0];
        else if (tx_ok_i && tec_q != '0) tec_q <= tec_q - 1'b1;

        if (rx_up) begin
          if (rec_q < REC_PAS) rec_q <= rec_q + REC_STEP;
        end else if (rx_ok_i) begin
          if (rec_q >= REC_PAS) rec_q <= REC_RLD;
          else if (rec_q != '0) rec_q <= rec_q - 1'b1;
        end
      end
    end
  end

  assign tec_o         = tec_q;
  assign rec_o         = rec_q;
  assign recov_irq_o   = irq_q;
  assign state_o       = off_q ? ST_OFF
                       : ((tec_q >= TEC_PAS || rec_q >= REC_PAS) ? ST_PAS : ST_ACT);
  assign err_passive_o = (state_o == ST_PAS);
endmodule

// File: rtl/can_fault_conf_chk.sv
module can_fault_conf_chk #(
  parameter int TEC_W    = 9,
  parameter int REC_W    = 8,
  parameter int PASS_LIM = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_err_i,
  input logic             rx_err_i,
  input logic             dom_seq_err_i,
  input logic             tx_ok_i,
  input logic             bit_stb_i,
  input logic             irq_ack_i,
  input logic [TEC_W-1:0] tec_o,
  input logic [REC_W-1:0] rec_o,
  input logic [1:0]       state_o,
  input logic             err_passive_o,
  input logic             recov_irq_o
);
  localparam logic [1:0] OFF = 2'b10;
  localparam logic [1:0] PAS = 2'b01;

  a_r4_tec_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != OFF && tec_o == '0 && tx_ok_i && !tx_err_i && !dom_seq_err_i)
      |=> (tec_o == '0));

  a_r3_rec_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != OFF && rec_o >= REC_W'(PASS_LIM) && rx_err_i && !tx_err_i && !dom_seq_err_i)
      |=> $stable(rec_o));

  a_r7_passive_map: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != OFF) |->
      ((state_o == PAS) == (tec_o >= TEC_W'(PASS_LIM) || rec_o >= REC_W'(PASS_LIM)))
      && (err_passive_o == (state_o == PAS)));

  a_r8_offentry_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != OFF) ##1 (state_o == OFF) |-> (tec_o == '0 && rec_o == '0));

  a_r9_off_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == OFF && !bit_stb_i) |=> ($stable(tec_o) && $stable(rec_o) && state_o == OFF));

  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (recov_irq_o && !irq_ack_i) |=> recov_irq_o);
endmodule

bind can_fault_conf can_fault_conf_chk #(
  .TEC_W(TEC_W), .REC_W(REC_W), .PASS_LIM(PASS_LIM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_err_i(tx_err_i), .rx_err_i(rx_err_i),
  .dom_seq_err_i(dom_seq_err_i), .tx_ok_i(tx_ok_i), .bit_stb_i(bit_stb_i),
  .irq_ack_i(irq_ack_i), .tec_o(tec_o), .rec_o(rec_o), .state_o(state_o),
  .err_passive_o(err_passive_o), .recov_irq_o(recov_irq_o)
);

// File: tb/can_fault_conf_tb.sv
module can_fault_conf_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_err, rx_err, dom_err, tx_ok, rx_ok, stb, lvl, ack;
  logic [8:0] tec;
  logic [7:0] rec;
  logic [1:0] state;
  logic passive, irq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_tec, m_rec, m_run;
  bit m_off, m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  can_fault_conf u_dut (
    .clk(clk), .rst_n(rst_n), .tx_err_i(tx_err), .rx_err_i(rx_err),
    .dom_seq_err_i(dom_err), .tx_ok_i(tx_ok), .rx_ok_i(rx_ok),
    .bit_stb_i(stb), .bit_lvl_i(lvl), .irq_ack_i(ack),
    .tec_o(tec), .rec_o(rec), .state_o(state),
    .err_passive_o(passive), .recov_irq_o(irq)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic int exp_state();
    if (m_off) return 2;
    return (m_tec >= 128 || m_rec >= 128) ? 1 : 0;
  endfunction

  task automatic model(bit te, bit re, bit de, bit to, bit ro, bit s, bit l, bit a);
    bit rec_now = 0;
    if (m_off) begin
      if (s) begin
        if (!l) m_run = 0;
        else if (m_run == 10) begin
          m_run = 0;
          if (m_rec == 127) begin m_off = 0; m_rec = 0; m_tec = 0; rec_now = 1; end
          else m_rec++;
        end else m_run++;
      end
    end else if ((te || de) && m_tec + 8 >= 256) begin
      m_off = 1; m_tec = 0; m_rec = 0; m_run = 0;
    end else begin
      if (te || de) m_tec += 8;
      else if (to && m_tec > 0) m_tec--;
      if (re || de) begin if (m_rec < 128) m_rec += 8; end
      else if (ro) begin
        if (m_rec > 127) m_rec = 120;
        else if (m_rec > 0) m_rec--;
      end
    end
    if (rec_now) m_irq = 1;
    else if (a) m_irq = 0;
  endtask

  task automatic compare_all();
    chk("R2/R8 tec", int'(tec), m_tec);
    chk("R3/R9 rec", int'(rec), m_rec);
    chk("R7 state", int'(state), exp_state());
    chk("R7 passive", int'(passive), int'(exp_state() == 1));
    chk("R10 irq", int'(irq), int'(m_irq));
  endtask

  task automatic step(bit te, bit re, bit de, bit to, bit ro, bit s, bit l, bit a);
    {tx_err, rx_err, dom_err, tx_ok, rx_ok, stb, lvl, ack} = {te, re, de, to, ro, s, l, a};
    model(te, re, de, to, ro, s, l, a);
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(); step(0,0,0,0,0,0,1,0); endtask

  task automatic do_reset();
    {tx_err, rx_err, dom_err, tx_ok, rx_ok, stb, lvl, ack} = 8'b0000_0010;
    rst_n = 1'b0;
    m_tec = 0; m_rec = 0; m_run = 0; m_off = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rand_phase(int n, int p_err, int p_ok, int p_dom);
    for (int i = 0; i < n; i++)
      step($urandom_range(99) < p_err, $urandom_range(99) < p_err,
           $urandom_range(999) < 5, $urandom_range(99) < p_ok,
           $urandom_range(99) < p_ok, $urandom_range(99) < 60,
           $urandom_range(99) >= p_dom, $urandom_range(99) < 3);
  endtask

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    chk("R1 reset tec", int'(tec), 0);
    chk("R1 reset rec", int'(rec), 0);
    chk("R1 reset state", int'(state), 0);
    chk("R1 reset irq", int'(irq), 0);

    step(0,0,0,1,1,0,1,0);
    chk("R4 tec floor at 0", int'(tec), 0);
    chk("R5 rec floor at 0", int'(rec), 0);
    for (int i = 0; i < 16; i++) step(0,1,0,0,0,0,1,0);
    chk("R3 rec after 16 errors", int'(rec), 128);
    chk("R7 passive from rec", int'(state), 1);
    step(0,1,0,0,0,0,1,0);
    chk("R3 rec saturated", int'(rec), 128);
    step(0,0,0,0,1,0,1,0);
    chk("R5 reload 120", int'(rec), 120);
    chk("R7 back to active", int'(state), 0);
    step(0,0,0,0,1,0,1,0);
    chk("R5 rec decrement", int'(rec), 119);
    step(1,0,0,1,0,0,1,0);
    chk("R6 increment wins tec", int'(tec), 8);
    step(0,1,0,0,1,0,1,0);
    chk("R6 increment wins rec", int'(rec), 127);
    step(0,0,0,1,0,0,1,0);
    chk("R4 tec decrement", int'(tec), 7);
    step(0,0,1,0,0,0,1,0);
    chk("R2 dom seq tec", int'(tec), 15);
    chk("R2 dom seq rec", int'(rec), 135);
    for (int i = 0; i < 30; i++) step(1,0,0,0,0,0,1,0);
    chk("R2 tec 255", int'(tec), 255);
    step(1,0,0,0,0,0,1,0);
    chk("R8 bus off state", int'(state), 2);
    chk("R8 tec cleared", int'(tec), 0);
    chk("R8 rec cleared", int'(rec), 0);
    step(1,1,1,1,1,0,1,0);
    chk("R9 events ignored tec", int'(tec), 0);
    chk("R9 events ignored rec", int'(rec), 0);
    for (int i = 0; i < 10; i++) step(0,0,0,0,0,1,1,0);
    step(0,0,0,0,0,1,0,0);
    step(0,0,0,0,0,1,1,0);
    chk("R9 dominant restarts run", int'(rec), 0);
    for (int i = 0; i < 10; i++) step(0,0,0,0,0,1,1,0);
    chk("R9 first run counted", int'(rec), 1);
    for (int i = 0; i < 126 * 11 + 10; i++) step(0,0,0,0,0,1,1,0);
    chk("R9 still bus off", int'(state), 2);
    chk("R9 run count 127", int'(rec), 127);
    step(0,0,0,0,0,1,1,0);
    chk("R10 recovered state", int'(state), 0);
    chk("R10 irq set", int'(irq), 1);
    chk("R10 counters cleared", int'(tec) + int'(rec), 0);
    repeat (5) idle();
    chk("R10 irq sticky", int'(irq), 1);
    step(0,0,0,0,0,0,1,1);
    chk("R10 irq acked", int'(irq), 0);

    do_reset();
    rand_phase(4000, 10, 20, 5);
    rand_phase(20000, 30, 5, 4);
    rand_phase(4000, 5, 40, 8);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule